// File: doc/BRIEF.md
# Iterative AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key with the AES-128 algorithm. It has one round datapath that runs once per clock. A single input pulse starts the job. The direction, key and data are captured on that pulse, and later changes to them do nothing. When the job ends, the result stays on the output and a one-cycle completion strobe fires. The round keys are not stored. They are derived one per cycle from the previous round key.

Both directions run through the same round hardware. Each round first reorders the bytes of the state and substitutes them, then mixes the columns, then adds the round key. Decryption uses the equivalent inverse ordering, so its rounds have the same shape as encryption rounds. Its middle round keys pass through the inverse column mix before they are added. Decryption needs the last round key first. It therefore spends ten cycles expanding the key forward before its rounds begin, and then walks the schedule backwards one step per round.

The byte substitution uses one shared finite-field inverter per lane. An affine map is applied after the inverter when encrypting, and the inverse affine map is applied before it when decrypting.

Top module: `aes_core`

## Requirements
- R1: While rst_ni is low, busy_o and done_o are 0 and dout_o is all zeros.
- R2: Byte 0 of every 128-bit value is in bits [127:120] and byte 15 is in bits [7:0]. With decrypt_i = 0, the result is the AES-128 encryption. Key 000102030405060708090a0b0c0d0e0f and data 00112233445566778899aabbccddeeff give 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: With decrypt_i = 1, the result is the AES-128 decryption. The same key with data 69c4e0d86a7b0430d8cdb78070b4c55a gives 00112233445566778899aabbccddeeff.
- R4: Suppose start_i is sampled high at rising edge n while the block is idle, with decrypt_i = 0. Then busy_o is high after edges n to n+9, and the result appears with done_o after edge n+10. That is eleven edges counting edge n.
- R5: A decryption accepted at edge n first spends ten cycles on the key schedule. It completes after edge n+20.
- R6: done_o is high for exactly one cycle per block, and busy_o is low in that cycle.
- R7: A start_i pulse while busy_o is high is ignored. The running block's result and completion time do not change, and no extra block follows.
- R8: decrypt_i, key_i and din_i are used only at the edge that accepts start_i. Changing them while busy has no effect on the result.
- R9: dout_o holds the last result, from its completion until the next completion, including while a new block runs.
- R10: start_i sampled in the cycle where done_o is high is accepted immediately.
- R11: For any key and data, decrypting the encryption returns the original data, and both results match the AES-128 definition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| decrypt_i | input | 1 | 1 selects decryption, 0 encryption |
| key_i | input | 128 | Cipher key |
| din_i | input | 128 | Input block |
| busy_o | output | 1 | A block is being processed |
| done_o | output | 1 | One-cycle completion strobe |
| dout_o | output | 128 | Result of the last block, held |

## Verification
The hardest states to reach from the ports involve start requests that arrive in the middle of a job. The first case is a start request while busy that carries a different direction, key and data. The second is a start request placed in the exact cycle where done_o is high. The bench reaches the first by raising start_i mid-run and flipping every other input at the same time; the result still has to match the original job and its timing. It reaches the second by issuing the next request in the same cycle that done_o is observed. Encryptions chained directly into decryptions also test the backward key walk, which runs only after a full forward precompute.

// File: rtl/aes_pkg.sv
package aes_pkg;

    localparam int BYTE_W = 8;
    localparam int NCOL   = 4;
    localparam int NROW   = 4;
    localparam int NBYTE  = NCOL * NROW;
    localparam int BLK_W  = NBYTE * BYTE_W;
    localparam int WORD_W = NROW * BYTE_W;
    localparam int NRND   = 10;
    localparam int RND_W  = $clog2(NRND + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_KEYPRE = 2'd1,
        PH_ROUND  = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t           ph;
        logic             dec;
        logic [RND_W-1:0] rnd;
        blk_t             st;
        blk_t             rk;
        blk_t             dout;
        logic             done;
    } core_regs_t;

    // multiply by x modulo the field polynomial
    function automatic byte_t xt(byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t p = 8'h00;
        byte_t s = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ s;
            s = xt(s);
        end
        return p;
    endfunction

    // inverse as a^254; zero maps to zero
    function automatic byte_t gf_inv(byte_t a);
        byte_t r = 8'h01;
        byte_t s = a;
        logic [7:0] e = 8'hfe;
        for (int i = 0; i < BYTE_W; i++) begin
            if (e[i]) r = gf_mul(r, s);
            s = gf_mul(s, s);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(byte_t b, int n);
        return byte_t'((b << n) | (b >> (BYTE_W - n)));
    endfunction

    function automatic byte_t aff_fwd(byte_t b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic byte_t aff_inv(byte_t b);
        return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
    endfunction

    function automatic byte_t getb(blk_t v, int idx);
        return v[BLK_W-1-BYTE_W*idx -: BYTE_W];
    endfunction

    function automatic byte_t rcon(int i);
        byte_t r = 8'h01;
        for (int k = 1; k < NRND; k++) begin
            if (k < i) r = xt(r);
        end
        return r;
    endfunction

    function automatic word_t mix_fwd(word_t c);
        byte_t a0 = c[31:24];
        byte_t a1 = c[23:16];
        byte_t a2 = c[15:8];
        byte_t a3 = c[7:0];
        return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
                xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
    endfunction

    function automatic word_t mix_inv(word_t c);
        byte_t a0 = c[31:24];
        byte_t a1 = c[23:16];
        byte_t a2 = c[15:8];
        byte_t a3 = c[7:0];
        return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
                gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
                gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
                gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
    endfunction

endpackage

// File: rtl/aes_sub_lane.sv
module aes_sub_lane
    import aes_pkg::*;
(
    input  logic  inv_i,
    input  byte_t a_i,
    output byte_t y_o
);

    byte_t pre_s;
    byte_t mid_s;

    // one inverter shared by both directions; the affine side moves
    always_comb begin
        pre_s = inv_i ? aff_inv(a_i) : a_i;
        mid_s = gf_inv(pre_s);
        y_o   = inv_i ? mid_s : aff_fwd(mid_s);
    end

endmodule

// File: rtl/aes_keystep.sv
module aes_keystep
    import aes_pkg::*;
(
    input  blk_t  rk_i,
    input  byte_t rc_i,
    input  logic  back_i,
    input  logic  mixk_i,
    output blk_t  nxt_o,
    output blk_t  use_o
);

    word_t w0, w1, w2, w3;
    word_t p3, sel, rot, sw, t;
    byte_t sb_in  [NROW];
    byte_t sb_out [NROW];

    assign w0  = rk_i[127:96];
    assign w1  = rk_i[95:64];
    assign w2  = rk_i[63:32];
    assign w3  = rk_i[31:0];
    assign p3  = w3 ^ w2;
    assign sel = back_i ? p3 : w3;
    assign rot = {sel[23:0], sel[31:24]};

    for (genvar b = 0; b < NROW; b++) begin : g_sub
        assign sb_in[b] = rot[WORD_W-1-BYTE_W*b -: BYTE_W];
        aes_sub_lane u_lane (
            .inv_i (1'b0),
            .a_i   (sb_in[b]),
            .y_o   (sb_out[b])
        );
        assign sw[WORD_W-1-BYTE_W*b -: BYTE_W] = sb_out[b];
    end

    assign t = sw ^ {rc_i, {(WORD_W-BYTE_W){1'b0}}};

    always_comb begin
        word_t n0, n1, n2, n3;
        if (back_i) begin
            n3 = p3;
            n2 = w2 ^ w1;
            n1 = w1 ^ w0;
            n0 = w0 ^ t;
        end else begin
            n0 = w0 ^ t;
            n1 = w1 ^ n0;
            n2 = w2 ^ n1;
            n3 = w3 ^ n2;
        end
        nxt_o = {n0, n1, n2, n3};
        use_o = nxt_o;
        if (mixk_i) begin
            for (int c = 0; c < NCOL; c++) begin
                use_o[BLK_W-1-WORD_W*c -: WORD_W] = mix_inv(nxt_o[BLK_W-1-WORD_W*c -: WORD_W]);
            end
        end
    end

endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_pkg::*;
(
    input  blk_t st_i,
    input  blk_t key_i,
    input  logic dec_i,
    input  logic last_i,
    output blk_t st_o
);

    byte_t lane_in  [NBYTE];
    byte_t lane_out [NBYTE];

    // row rotation folded into the lane input select, then substitution
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar r = 0; r < NROW; r++) begin : g_row
            localparam int SRC_E = NROW * ((c + r) % NCOL) + r;
            localparam int SRC_D = NROW * ((c + NCOL - r) % NCOL) + r;
            assign lane_in[NROW*c+r] = dec_i ? getb(st_i, SRC_D) : getb(st_i, SRC_E);
            aes_sub_lane u_lane (
                .inv_i (dec_i),
                .a_i   (lane_in[NROW*c+r]),
                .y_o   (lane_out[NROW*c+r])
            );
        end

        word_t col_s;
        word_t mixed_s;
        assign col_s = {lane_out[NROW*c], lane_out[NROW*c+1],
                        lane_out[NROW*c+2], lane_out[NROW*c+3]};
        assign mixed_s = last_i ? col_s : (dec_i ? mix_inv(col_s) : mix_fwd(col_s));
        assign st_o[BLK_W-1-WORD_W*c -: WORD_W] = mixed_s ^ key_i[BLK_W-1-WORD_W*c -: WORD_W];
    end

endmodule

// File: rtl/aes_core.sv
module aes_core
    import aes_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             decrypt_i,
    input  logic [BLK_W-1:0] key_i,
    input  logic [BLK_W-1:0] din_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [BLK_W-1:0] dout_o
);

    localparam logic [RND_W-1:0] RND_FIRST = RND_W'(1);
    localparam logic [RND_W-1:0] RND_LAST  = RND_W'(NRND);

    core_regs_t r_d, r_q;

    blk_t  ks_nxt, ks_use, rd_out;
    byte_t ks_rc;
    logic  ks_back, ks_mixk, fin;

    assign fin     = r_q.dec ? (r_q.rnd == RND_FIRST) : (r_q.rnd == RND_LAST);
    assign ks_back = r_q.dec && (r_q.ph == PH_ROUND);
    assign ks_mixk = ks_back && !fin;
    assign ks_rc   = rcon(int'(r_q.rnd));

    aes_keystep u_keystep (
        .rk_i   (r_q.rk),
        .rc_i   (ks_rc),
        .back_i (ks_back),
        .mixk_i (ks_mixk),
        .nxt_o  (ks_nxt),
        .use_o  (ks_use)
    );

    aes_round u_round (
        .st_i   (r_q.st),
        .key_i  (ks_use),
        .dec_i  (r_q.dec),
        .last_i (fin),
        .st_o   (rd_out)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.dec = decrypt_i;
                    r_d.rk  = key_i;
                    r_d.rnd = RND_FIRST;
                    if (decrypt_i) begin
                        r_d.st = din_i;
                        r_d.ph = PH_KEYPRE;
                    end else begin
                        r_d.st = din_i ^ key_i;
                        r_d.ph = PH_ROUND;
                    end
                end
            end
            PH_KEYPRE: begin
                r_d.rk = ks_nxt;
                if (r_q.rnd == RND_LAST) begin
                    r_d.st = r_q.st ^ ks_nxt;
                    r_d.ph = PH_ROUND;
                end else begin
                    r_d.rnd = r_q.rnd + RND_FIRST;
                end
            end
            PH_ROUND: begin
                r_d.st = rd_out;
                r_d.rk = ks_nxt;
                if (fin) begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                    r_d.dout = rd_out;
                end else if (r_q.dec) begin
                    r_d.rnd = r_q.rnd - RND_FIRST;
                end else begin
                    r_d.rnd = r_q.rnd + RND_FIRST;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign busy_o = (r_q.ph != PH_IDLE);
    assign done_o = r_q.done;
    assign dout_o = r_q.dout;

    assert_done_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    assert_dout_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(dout_o));

    assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (!busy_o || $stable(r_q.dec)));

    assert_rnd_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (r_q.rnd >= RND_FIRST && r_q.rnd <= RND_LAST));

    assert_busy_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

endmodule

// File: tb/test_aes_core.sv
module test_aes_core;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic         decrypt;
    logic [127:0] key;
    logic [127:0] din;
    logic         busy;
    logic         done;
    logic [127:0] dout;

    int checks = 0;
    int errors = 0;

    localparam logic [127:0] FK = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] FP = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] FC = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

    always #5 clk = ~clk;

    aes_core i_aes_core (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .decrypt_i (decrypt),
        .key_i     (key),
        .din_i     (din),
        .busy_o    (busy),
        .done_o    (done),
        .dout_o    (dout)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] sb  [256];
    logic [7:0] isb [256];

    function automatic logic [7:0] b_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[0]) p = p ^ a;
            a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
            b = b >> 1;
        end
        return p;
    endfunction

    task automatic build_tables();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv = 8'h00;
            logic [7:0] s;
            if (x != 0) begin
                for (int y = 1; y < 256; y++) begin
                    if (b_mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
                end
            end
            for (int i = 0; i < 8; i++) begin
                s[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8] ^ iv[(i+7)%8];
            end
            s = s ^ 8'h63;
            sb[x]  = s;
            isb[s] = 8'(x);
        end
    endtask

    function automatic logic [127:0] ref_rkey(logic [127:0] k, int n);
        logic [127:0] cur = k;
        logic [7:0]   rc  = 8'h01;
        for (int i = 1; i <= n; i++) begin
            logic [31:0] tw = {cur[23:0], cur[31:24]};
            logic [31:0] w0, w1, w2, w3;
            tw = {sb[tw[31:24]], sb[tw[23:16]], sb[tw[15:8]], sb[tw[7:0]]};
            tw[31:24] = tw[31:24] ^ rc;
            w0 = cur[127:96] ^ tw;
            w1 = cur[95:64] ^ w0;
            w2 = cur[63:32] ^ w1;
            w3 = cur[31:0] ^ w2;
            cur = {w0, w1, w2, w3};
            rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
        end
        return cur;
    endfunction

    function automatic logic [127:0] mixv(logic [127:0] v, bit inv);
        logic [7:0] ce [4] = '{8'h02, 8'h03, 8'h01, 8'h01};
        logic [7:0] cd [4] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
        logic [127:0] o;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] acc = 8'h00;
                for (int j = 0; j < 4; j++) begin
                    logic [7:0] a = v[127-8*(4*c+j) -: 8];
                    acc = acc ^ b_mul(inv ? cd[(j-r+4)%4] : ce[(j-r+4)%4], a);
                end
                o[127-8*(4*c+r) -: 8] = acc;
            end
        end
        return o;
    endfunction

    function automatic logic [127:0] ref_enc(logic [127:0] k, logic [127:0] p);
        logic [127:0] s = p ^ k;
        for (int rn = 1; rn <= 10; rn++) begin
            logic [127:0] t;
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    t[127-8*(4*c+r) -: 8] = sb[s[127-8*(4*((c+r)%4)+r) -: 8]];
            if (rn < 10) t = mixv(t, 1'b0);
            s = t ^ ref_rkey(k, rn);
        end
        return s;
    endfunction

    function automatic logic [127:0] ref_dec(logic [127:0] k, logic [127:0] x);
        logic [127:0] s = x ^ ref_rkey(k, 10);
        for (int rn = 9; rn >= 0; rn--) begin
            logic [127:0] t;
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    t[127-8*(4*c+r) -: 8] = isb[s[127-8*(4*((c+4-r)%4)+r) -: 8]];
            t = t ^ ref_rkey(k, rn);
            if (rn > 0) t = mixv(t, 1'b1);
            s = t;
        end
        return s;
    endfunction

    // ---------------- cycle model ----------------
    bit           m_busy = 1'b0;
    bit           m_done = 1'b0;
    int           m_cnt  = 0;
    logic [127:0] m_out  = '0;
    logic [127:0] m_res  = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_out = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_out = m_res;
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_cnt  = decrypt ? 20 : 10;
                m_res  = decrypt ? ref_dec(key, din) : ref_enc(key, din);
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (busy !== m_busy || done !== m_done || dout !== m_out) begin
            errors++;
            $display("FAIL R4 R6 R9 cycle: actual busy=%b done=%b dout=%h expected busy=%b done=%b dout=%h",
                     busy, done, dout, m_busy, m_done, m_out);
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_block(input logic d, input logic [127:0] k, input logic [127:0] x,
                            input int poke, output logic [127:0] res, output int lat);
        logic [127:0] prev = dout;
        decrypt = d; key = k; din = x; start = 1'b1; lat = 0;
        while (1'b1) begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
            if (poke > 0 && lat == poke) begin
                start = 1'b1; decrypt = ~d; key = ~k; din = ~x;
            end
            if (poke > 0 && lat == poke + 1) start = 1'b0;
            if (lat == 5) chk("R9 output held during run", dout, prev);
            if (done) break;
            if (lat > 60) begin
                errors++;
                $display("FAIL R4 no completion: actual lat=%0d expected done", lat);
                break;
            end
        end
        res = dout;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] res, res2;
        int lat;
        build_tables();
        rst_n = 1'b0; start = 1'b0; decrypt = 1'b0; key = '0; din = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 128'(busy), 128'd0);
        chk("R1 reset done", 128'(done), 128'd0);
        chk("R1 reset dout", dout, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_block(1'b0, FK, FP, 0, res, lat);
        chk("R2 encrypt vector", res, FC);
        chk("R4 encrypt latency", 128'(lat), 128'd11);
        chk("R6 busy low with done", 128'(busy), 128'd0);
        @(negedge clk);
        chk("R6 done one cycle", 128'(done), 128'd0);
        repeat (4) @(negedge clk);
        chk("R9 output held while idle", dout, FC);

        do_block(1'b1, FK, FC, 0, res, lat);
        chk("R3 decrypt vector", res, FP);
        chk("R5 decrypt latency", 128'(lat), 128'd21);
        @(negedge clk);

        do_block(1'b0, FK, FP, 4, res, lat);
        chk("R7 start while busy latency", 128'(lat), 128'd11);
        chk("R8 inputs changed while busy", res, FC);
        repeat (3) @(negedge clk);
        chk("R7 no extra block", 128'(busy), 128'd0);

        do_block(1'b1, FK, FC, 7, res, lat);
        chk("R8 decrypt inputs changed while busy", res, FP);
        chk("R7 decrypt latency with poke", 128'(lat), 128'd21);
        @(negedge clk);

        do_block(1'b0, FK, FP, 0, res, lat);
        do_block(1'b1, FK, res, 0, res2, lat);
        chk("R10 back-to-back accepted", 128'(lat), 128'd21);
        chk("R10 back-to-back result", res2, FP);

        for (int i = 0; i < 4; i++) begin
            logic [127:0] rk = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] rp = {$urandom, $urandom, $urandom, $urandom};
            do_block(1'b0, rk, rp, 0, res, lat);
            chk("R11 random encrypt", res, ref_enc(rk, rp));
            do_block(1'b1, rk, res, 0, res2, lat);
            chk("R11 random round trip", res2, rp);
        end

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule